// File: doc/BRIEF.md
# Vectored Peripheral Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests from peripherals and turns them into one request line toward a host processor, along with a 3-bit processor interrupt level. Software programs it through four word registers on a simple write-strobe bus with combinational read data. The registers are a configuration word, a per-source enable mask, an in-service word and a vector word.

When the processor takes the interrupt, it writes 1 to bit 0 of the vector word. This acknowledge latches the highest-ranked pending, unmasked source and marks that source in service. The following read of the vector word returns the source number in bits 15:11. The handler ends by writing a one to the source's in-service bit. While a source is in service, only sources that rank above it can raise the request line.

By default a larger source number ranks higher. The configuration word can promote one chosen source above all others. A request can disappear between the time the request line rises and the time the acknowledge arrives, for example when software masks the source in that window. In that case the acknowledge latches the error vector (0), marks nothing in service, and pulses a separate error output.

Top module: `pirq_ctrl`

## Requirements
- R1: After reset the configuration, mask, in-service and vector registers all read 0, the request output is low, the level output is 0 and the error output is low.
- R2: Register 1 is the mask: bit i = 1 enables source i and bit i = 0 masks it. A masked source never raises the request and is never chosen by an acknowledge.
- R3: Register 0 bit 0 is the global enable. While it is 0 the request output stays low, whatever the sources are doing.
- R4: Register 0 bits 15:13 hold the processor interrupt level. The level output always equals this field.
- R5: Among eligible sources (input high, unmasked, and ranked above every in-service source), the one with the largest number wins by default.
- R6: When register 0 bit 7 is 1, the source numbered by register 0 bits 12:8 ranks above every other source.
- R7: Writing register 3 with bit 0 = 1 is an acknowledge. It latches the winning source number, which register 3 then returns in bits 15:11 with all other bits 0. A write with bit 0 = 0 leaves the vector unchanged.
- R8: An acknowledge with a winner sets that source's bit in register 2. After that, the request output is high only if the global enable is set and some eligible source ranks above every in-service source.
- R9: Writing register 2 clears each in-service bit whose data bit is 1. Data bits of 0 leave their in-service bits unchanged.
- R10: Requests are level-sensitive and not stored. When a source input falls, the request it caused is withdrawn on the same cycle.
- R11: An acknowledge with no eligible source latches vector 0, sets no in-service bit, and raises the error output for exactly the one cycle after the acknowledge edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register index: 0 config, 1 mask, 2 in-service, 3 vector |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Combinational read data of the addressed register |
| irq_src_i | input | 32 | Level-sensitive source requests, bit i is source i |
| cpu_irq_req_o | output | 1 | Request line to the processor |
| cpu_irq_level_o | output | 3 | Processor interrupt level from the configuration field |
| ack_err_o | output | 1 | One-cycle pulse after an acknowledge that found no eligible source |

## Verification
The directed patterns place several sources at once across the range, and each pattern separates one effect. A set of low, middle and high sources tells the default ranking apart from the override ranking. Raising a higher source while a middle one is in service shows that nested requests are blocked or allowed correctly. Masking every source just before an acknowledge checks the error path against a normal acknowledge. Seeded random sequences then mix source changes, configuration, mask and clear writes, and acknowledges. Each result is compared with a ranking model, which exposes wrong priority, stale in-service state and errors in clear-on-one handling.

// File: rtl/pirq_pkg.sv
package pirq_pkg;

   localparam int REG_IDX_W   = 2;
   localparam int VEC_FIELD_W = 5;

   typedef enum logic [REG_IDX_W-1:0] {
      RSEL_CFG   = 2'd0,
      RSEL_MASK  = 2'd1,
      RSEL_INSVC = 2'd2,
      RSEL_VEC   = 2'd3
   } rsel_e;

   // configuration word layout
   localparam int CFG_GIE_BIT    = 0;
   localparam int CFG_OVR_EN_BIT = 7;
   localparam int CFG_OVR_LO     = 8;
   localparam int CFG_OVR_HI     = 12;
   localparam int CFG_LVL_LO     = 13;
   localparam int CFG_LVL_HI     = 15;

   // vector word layout
   localparam int VEC_ACK_BIT = 0;
   localparam int VEC_LO      = 11;
   localparam int VEC_HI      = 15;

   typedef struct packed {
      logic [2:0]             level;
      logic [VEC_FIELD_W-1:0] ovr_sel;
      logic                   ovr_en;
      logic                   gie;
   } cfg_t;

endpackage

// File: rtl/pirq_prio.sv
module pirq_prio
   import pirq_pkg::*;
#(
   parameter int NUM_SRC       = 32,
   parameter bit HIGH_NUM_WINS = 1'b1,
   localparam int IDX_W        = $clog2(NUM_SRC),
   localparam int RANK_W       = $clog2(NUM_SRC + 1)
) (
   input  logic [NUM_SRC-1:0]     pend_i,
   input  logic [NUM_SRC-1:0]     isr_i,
   input  logic                   ovr_en_i,
   input  logic [VEC_FIELD_W-1:0] ovr_sel_i,
   output logic                   elig_any_o,
   output logic [IDX_W-1:0]       win_idx_o
);

   logic [RANK_W-1:0] base_w [NUM_SRC];
   logic [RANK_W-1:0] rank_w [NUM_SRC];
   logic [NUM_SRC-1:0] elig_w;

   logic              isv_any;
   logic [RANK_W-1:0] isv_max;
   logic              win_any;
   logic [RANK_W-1:0] win_rank;

   // static order, picked at elaboration
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_rank
      if (HIGH_NUM_WINS) begin : g_hi
         assign base_w[g] = RANK_W'(g);
      end else begin : g_lo
         assign base_w[g] = RANK_W'(NUM_SRC - 1 - g);
      end
      // promoted source sits above every static rank
      assign rank_w[g] = (ovr_en_i && (ovr_sel_i == VEC_FIELD_W'(g)))
                         ? RANK_W'(NUM_SRC) : base_w[g];
   end

   // highest rank currently in service
   always_comb begin
      isv_any = 1'b0;
      isv_max = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (isr_i[i] && (!isv_any || rank_w[i] > isv_max)) begin
            isv_any = 1'b1;
            isv_max = rank_w[i];
         end
      end
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_elig
      assign elig_w[g] = pend_i[g] && (!isv_any || rank_w[g] > isv_max);
   end

   always_comb begin
      win_any   = 1'b0;
      win_rank  = '0;
      win_idx_o = '0;
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig_w[i] && (!win_any || rank_w[i] > win_rank)) begin
            win_any   = 1'b1;
            win_rank  = rank_w[i];
            win_idx_o = IDX_W'(i);
         end
      end
   end

   assign elig_any_o = |elig_w;

endmodule

// File: rtl/pirq_regs.sv
module pirq_regs
   import pirq_pkg::*;
#(
   parameter int          NUM_SRC = 32,
   parameter int          DATA_W  = 32,
   parameter int unsigned ERR_VEC = 0,
   localparam int IDX_W           = $clog2(NUM_SRC)
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 we_i,
   input  logic [REG_IDX_W-1:0] addr_i,
   input  logic [DATA_W-1:0]    wdata_i,
   output logic [DATA_W-1:0]    rdata_o,
   input  logic                 elig_any_i,
   input  logic [IDX_W-1:0]     win_idx_i,
   output cfg_t                 cfg_o,
   output logic [NUM_SRC-1:0]   mask_o,
   output logic [NUM_SRC-1:0]   isr_o,
   output logic [IDX_W-1:0]     vec_o,
   output logic                 err_o
);

   rsel_e              rsel;
   logic               wr_cfg, wr_mask, wr_isr, ack;
   cfg_t               cfg_q;
   logic [NUM_SRC-1:0] mask_q;
   logic [NUM_SRC-1:0] isr_q;
   logic [IDX_W-1:0]   vec_q;
   logic               err_q;

   assign rsel    = rsel_e'(addr_i);
   assign wr_cfg  = we_i && (rsel == RSEL_CFG);
   assign wr_mask = we_i && (rsel == RSEL_MASK);
   assign wr_isr  = we_i && (rsel == RSEL_INSVC);
   assign ack     = we_i && (rsel == RSEL_VEC) && wdata_i[VEC_ACK_BIT];

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= '0;
      end else if (wr_cfg) begin
         cfg_q.gie     <= wdata_i[CFG_GIE_BIT];
         cfg_q.ovr_en  <= wdata_i[CFG_OVR_EN_BIT];
         cfg_q.ovr_sel <= wdata_i[CFG_OVR_HI:CFG_OVR_LO];
         cfg_q.level   <= wdata_i[CFG_LVL_HI:CFG_LVL_LO];
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mask_q <= '0;
      end else if (wr_mask) begin
         mask_q <= wdata_i[NUM_SRC-1:0];
      end
   end

   // per-source in-service flop: set by winning ack, cleared by W1C
   for (genvar g = 0; g < NUM_SRC; g++) begin : g_isr
      logic hit;
      assign hit = ack && elig_any_i && (win_idx_i == IDX_W'(g));
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            isr_q[g] <= 1'b0;
         end else if (hit) begin
            isr_q[g] <= 1'b1;
         end else if (wr_isr && wdata_i[g]) begin
            isr_q[g] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         vec_q <= '0;
         err_q <= 1'b0;
      end else begin
         err_q <= 1'b0;
         if (ack) begin
            if (elig_any_i) begin
               vec_q <= win_idx_i;
            end else begin
               vec_q <= IDX_W'(ERR_VEC);
               err_q <= 1'b1;
            end
         end
      end
   end

   always_comb begin
      rdata_o = '0;
      unique case (rsel)
         RSEL_CFG: begin
            rdata_o[CFG_GIE_BIT]           = cfg_q.gie;
            rdata_o[CFG_OVR_EN_BIT]        = cfg_q.ovr_en;
            rdata_o[CFG_OVR_HI:CFG_OVR_LO] = cfg_q.ovr_sel;
            rdata_o[CFG_LVL_HI:CFG_LVL_LO] = cfg_q.level;
         end
         RSEL_MASK:  rdata_o[NUM_SRC-1:0]  = mask_q;
         RSEL_INSVC: rdata_o[NUM_SRC-1:0]  = isr_q;
         RSEL_VEC:   rdata_o[VEC_HI:VEC_LO] = VEC_FIELD_W'(vec_q);
         default:    rdata_o = '0;
      endcase
   end

   assign cfg_o  = cfg_q;
   assign mask_o = mask_q;
   assign isr_o  = isr_q;
   assign vec_o  = vec_q;
   assign err_o  = err_q;

endmodule

// File: rtl/pirq_ctrl.sv
module pirq_ctrl
   import pirq_pkg::*;
#(
   parameter int          NUM_SRC       = 32,
   parameter int          DATA_W        = 32,
   parameter bit          HIGH_NUM_WINS = 1'b1,
   parameter int unsigned ERR_VEC       = 0
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 bus_we_i,
   input  logic [REG_IDX_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0]    bus_wdata_i,
   output logic [DATA_W-1:0]    bus_rdata_o,
   input  logic [NUM_SRC-1:0]   irq_src_i,
   output logic                 cpu_irq_req_o,
   output logic [2:0]           cpu_irq_level_o,
   output logic                 ack_err_o
);

   localparam int IDX_W = $clog2(NUM_SRC);

   if (NUM_SRC < 2 || NUM_SRC > (1 << VEC_FIELD_W)) begin : g_bad_src
      $error("pirq_ctrl: NUM_SRC must lie in 2..32");
   end
   if (DATA_W < NUM_SRC || DATA_W < CFG_LVL_HI + 1) begin : g_bad_data
      $error("pirq_ctrl: DATA_W too narrow for the register fields");
   end
   if (ERR_VEC >= NUM_SRC) begin : g_bad_err
      $error("pirq_ctrl: ERR_VEC out of range");
   end

   cfg_t               cfg_w;
   logic [NUM_SRC-1:0] mask_w;
   logic [NUM_SRC-1:0] isr_w;
   logic [IDX_W-1:0]   vec_w;
   logic [NUM_SRC-1:0] pend_w;
   logic               elig_any_w;
   logic [IDX_W-1:0]   win_idx_w;
   logic               gie_w;

   assign pend_w = irq_src_i & mask_w;
   assign gie_w  = cfg_w.gie;

   pirq_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .ERR_VEC (ERR_VEC)
   ) u_regs (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .we_i       (bus_we_i),
      .addr_i     (bus_addr_i),
      .wdata_i    (bus_wdata_i),
      .rdata_o    (bus_rdata_o),
      .elig_any_i (elig_any_w),
      .win_idx_i  (win_idx_w),
      .cfg_o      (cfg_w),
      .mask_o     (mask_w),
      .isr_o      (isr_w),
      .vec_o      (vec_w),
      .err_o      (ack_err_o)
   );

   pirq_prio #(
      .NUM_SRC       (NUM_SRC),
      .HIGH_NUM_WINS (HIGH_NUM_WINS)
   ) u_prio (
      .pend_i     (pend_w),
      .isr_i      (isr_w),
      .ovr_en_i   (cfg_w.ovr_en),
      .ovr_sel_i  (cfg_w.ovr_sel),
      .elig_any_o (elig_any_w),
      .win_idx_o  (win_idx_w)
   );

   assign cpu_irq_req_o   = gie_w && elig_any_w;
   assign cpu_irq_level_o = cfg_w.level;

endmodule

// File: rtl/pirq_ctrl_chk.sv
module pirq_ctrl_chk #(
   parameter int          NUM_SRC = 32,
   parameter int unsigned ERR_VEC = 0,
   localparam int IDX_W           = $clog2(NUM_SRC)
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               req_i,
   input logic               gie_i,
   input logic [NUM_SRC-1:0] src_i,
   input logic [NUM_SRC-1:0] mask_i,
   input logic [NUM_SRC-1:0] isr_i,
   input logic [IDX_W-1:0]   vec_i,
   input logic               err_i
);

   // R3: request only while globally enabled
   a_r3_req_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |-> gie_i);

   // R2 / R10: request only with a live unmasked input
   a_r2_req_needs_live_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i |-> |(src_i & mask_i));

   // R8: an acknowledge sets at most one new in-service bit
   a_r8_one_new_insvc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(isr_i & ~$past(isr_i)));

   // R11: error pulse carries the error vector
   a_r11_err_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i |-> (vec_i == IDX_W'(ERR_VEC)));

   // R11: failed acknowledge leaves in-service state untouched
   a_r11_err_no_insvc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      err_i |-> (isr_i == $past(isr_i)));

endmodule

bind pirq_ctrl pirq_ctrl_chk #(
   .NUM_SRC (NUM_SRC),
   .ERR_VEC (ERR_VEC)
) u_chk (
   .clk_i  (clk_i),
   .rst_ni (rst_ni),
   .req_i  (cpu_irq_req_o),
   .gie_i  (gie_w),
   .src_i  (irq_src_i),
   .mask_i (mask_w),
   .isr_i  (isr_w),
   .vec_i  (vec_w),
   .err_i  (ack_err_o)
);

// File: tb/test_pirq_ctrl.sv
`timescale 1ns/1ps
module test_pirq_ctrl;

   localparam logic [31:0] CFG_KEEP = 32'h0000_FF81;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = 2'd0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [31:0] irq_src = '0;
   logic        cpu_req;
   logic [2:0]  cpu_lvl;
   logic        ack_err;

   int n_chk = 0;
   int n_fail = 0;
   logic [31:0] m_cfg = '0, m_mask = '0, m_isr = '0, m_vec = '0;
   logic        exp_err = 1'b0;

   always #2 clk = ~clk;

   pirq_ctrl i_pirq_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .bus_we_i(bus_we), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .irq_src_i(irq_src),
      .cpu_irq_req_o(cpu_req), .cpu_irq_level_o(cpu_lvl), .ack_err_o(ack_err)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int rank_of(int i, logic [31:0] cfg);
      if (cfg[7] && cfg[12:8] == i[4:0]) return 32;
      return i;
   endfunction

   // winning source index or -1
   function automatic int best(logic [31:0] pend, logic [31:0] isr, logic [31:0] cfg);
      int imax = -1, bw = -1, br = -1;
      for (int i = 0; i < 32; i++)
         if (isr[i] && rank_of(i, cfg) > imax) imax = rank_of(i, cfg);
      for (int i = 0; i < 32; i++)
         if (pend[i] && rank_of(i, cfg) > imax && rank_of(i, cfg) > br) begin
            br = rank_of(i, cfg); bw = i;
         end
      return bw;
   endfunction

   task automatic do_write(input logic [1:0] a, input logic [31:0] d);
      int w;
      bit is_ack;
      is_ack = (a == 2'd3) && d[0];
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      exp_err = 1'b0;
      case (a)
         2'd0: m_cfg = d & CFG_KEEP;
         2'd1: m_mask = d;
         2'd2: m_isr = m_isr & ~d;
         default: if (d[0]) begin
            w = best(irq_src & m_mask, m_isr, m_cfg);
            if (w >= 0) begin m_vec = 32'(w); m_isr[w] = 1'b1; end
            else begin m_vec = 32'd0; exp_err = 1'b1; end
         end
      endcase
      @(negedge clk);
      bus_we = 1'b0;
      #1;
      chk("R11 error flag after write", {31'd0, ack_err}, {31'd0, exp_err});
      if (is_ack) begin
         @(negedge clk); #1;
         chk("R11 error flag one cycle", {31'd0, ack_err}, 32'd0);
      end
   endtask

   task automatic rd(input logic [1:0] a, input string tag, input logic [31:0] exp);
      @(negedge clk);
      bus_addr = a;
      #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic set_src(input logic [31:0] v);
      @(negedge clk);
      irq_src = v;
      #1;
   endtask

   task automatic check_outputs();
      bit exp_req;
      exp_req = m_cfg[0] && (best(irq_src & m_mask, m_isr, m_cfg) >= 0);
      chk("R8 request line", {31'd0, cpu_req}, {31'd0, exp_req});
      chk("R4 level output", {29'd0, cpu_lvl}, {29'd0, m_cfg[15:13]});
   endtask

   task automatic read_all();
      rd(2'd0, "R4 config readback", m_cfg);
      rd(2'd1, "R2 mask readback", m_mask);
      rd(2'd2, "R9 in-service readback", m_isr);
      rd(2'd3, "R7 vector readback", m_vec << 11);
   endtask

   initial begin
      int seed_dummy;
      seed_dummy = $urandom(32'd1357);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk("R1 request low", {31'd0, cpu_req}, 32'd0);
      chk("R1 level zero", {29'd0, cpu_lvl}, 32'd0);
      chk("R1 error low", {31'd0, ack_err}, 32'd0);
      rd(2'd0, "R1 config zero", 32'd0);
      rd(2'd1, "R1 mask zero", 32'd0);
      rd(2'd2, "R1 in-service zero", 32'd0);
      rd(2'd3, "R1 vector zero", 32'd0);

      // R2 masking
      do_write(2'd0, 32'h1);
      set_src(32'h20);
      chk("R2 masked source silent", {31'd0, cpu_req}, 32'd0);
      do_write(2'd1, 32'h20);
      chk("R2 unmasked source requests", {31'd0, cpu_req}, 32'd1);
      // R3 global enable
      do_write(2'd0, 32'h0);
      chk("R3 disabled blocks request", {31'd0, cpu_req}, 32'd0);
      // R4 level
      do_write(2'd0, 32'h0000_A001);
      chk("R4 level 5", {29'd0, cpu_lvl}, 32'd5);

      // R5 default order, R7 vector, R8 nesting
      set_src(32'h0010_0208);
      do_write(2'd1, 32'hFFFF_FFFF);
      do_write(2'd3, 32'h1);
      rd(2'd3, "R5 R7 highest number latched", 32'd20 << 11);
      rd(2'd2, "R8 in-service set", 32'h0010_0000);
      chk("R8 lower sources blocked", {31'd0, cpu_req}, 32'd0);
      set_src(32'h0210_0208);
      chk("R8 higher source passes", {31'd0, cpu_req}, 32'd1);
      do_write(2'd3, 32'h0);
      rd(2'd3, "R7 no-ack write keeps vector", 32'd20 << 11);
      // R9 write-one-to-clear
      do_write(2'd2, 32'h0000_0001);
      rd(2'd2, "R9 zero bits no effect", 32'h0010_0000);
      do_write(2'd2, 32'h0010_0000);
      rd(2'd2, "R9 one bit clears", 32'd0);

      // R6 override to source 3
      do_write(2'd0, 32'h0000_0381);
      set_src(32'h0010_0208);
      do_write(2'd3, 32'h1);
      rd(2'd3, "R6 promoted source wins", 32'd3 << 11);
      chk("R6 all others below promoted", {31'd0, cpu_req}, 32'd0);
      do_write(2'd2, 32'hFFFF_FFFF);

      // R10 level sensitivity
      set_src(32'h0);
      chk("R10 request withdrawn", {31'd0, cpu_req}, 32'd0);

      // R11 masking race
      set_src(32'h0000_8000);
      do_write(2'd1, 32'h0);
      do_write(2'd3, 32'h1);
      rd(2'd3, "R11 error vector", 32'd0);
      rd(2'd2, "R11 no in-service", 32'd0);

      // random phase
      for (int it = 0; it < 600; it++) begin
         int op;
         logic [31:0] d;
         op = int'($urandom_range(0, 5));
         case (op)
            0: set_src($urandom() & $urandom());
            1: begin
               d = $urandom();
               d[0] = ($urandom_range(0, 3) != 0);
               do_write(2'd0, d);
            end
            2: do_write(2'd1, $urandom());
            3: do_write(2'd2, $urandom() & $urandom());
            default: do_write(2'd3, 32'h1);
         endcase
         check_outputs();
         if (it % 8 == 0) read_all();
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule